// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one 32-bit integer by another over many clock cycles and returns a quotient and a remainder. It resolves one quotient bit per cycle with a restoring shift/subtract loop. Partial remainder and quotient share a single combined shift register: the partial remainder sits in the upper part and the quotient bits enter at the bottom. A subtractor as wide as the divisor acts only on the upper part. The combined register is shifted once before the loop begins. Because of that early shift, the remainder ends one position too far left, so one correction step at the end shifts it back right.

A caller presents the operands and a mode bit with a one-cycle `start` pulse while the block is idle. `busy` stays high while the loop runs, and `done` pulses once when the registered results become valid. In signed mode the block divides the magnitudes and then fixes the signs. The quotient truncates toward zero and the remainder takes the sign of the dividend. A zero divisor does not stall the block. It raises a flag and returns fixed, defined results in the normal number of cycles.

Top module: `seq_divider`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `busy`, `done` and `div_by_zero` are 0, and `quotient` and `remainder` are 0.
- R2: With `is_signed` = 0 the operands are unsigned, and the results are the unsigned quotient `dividend / divisor` and the remainder `dividend % divisor` (for example 7 / 2 gives 3 remainder 1).
- R3: `done` is high for exactly one cycle. It first becomes visible after the 33rd rising edge that follows the edge at which `start` was accepted. `busy` is high in every cycle in between and low while `done` is high.
- R4: With `is_signed` = 1 the operands are two's complement. The quotient truncates toward zero and a nonzero remainder has the sign of the dividend (for example -7 / 4 gives -1 remainder -3, 7 / -4 gives -1 remainder 3, and -7 / -4 gives 1 remainder -3).
- R5: A divisor of 0 sets `div_by_zero` to 1 with the result. `quotient` is all ones, `remainder` equals the dividend as presented, and the latency of R3 is kept. In every other case `div_by_zero` is 0 with the result.
- R6: `start` is accepted only while `busy` is 0. A `start` pulse while `busy` is 1 has no effect on the running division's results or timing.
- R7: The operands and mode are captured when `start` is accepted. Later changes on `dividend`, `divisor` and `is_signed` do not affect the result.
- R8: `quotient`, `remainder` and `div_by_zero` hold their values from one `done` pulse until the next result is written, both while idle and while busy.
- R9: In signed mode, the most negative value (0x80000000) divided by -1 returns quotient 0x80000000 and remainder 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a division; accepted only when idle |
| is_signed | input | 1 | 1 selects two's complement operands, 0 unsigned |
| dividend | input | 32 | Dividend, captured at accepted start |
| divisor | input | 32 | Divisor, captured at accepted start |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle pulse when the results become valid |
| quotient | output | 32 | Quotient of the latest division |
| remainder | output | 32 | Remainder of the latest division |
| div_by_zero | output | 1 | Latest division had a zero divisor |

## Verification
The assertions assume `start` is a plain level sampled at the clock and that reset is applied at the beginning of the run. They make no assumption about the operand values. The bench drives every input on the falling edge and holds `start` for exactly one cycle, so each accepted start maps to one clock edge. It deliberately pulses `start` during `busy` and changes the operands after acceptance, to exercise R6 and R7. It keeps the operand pairs with no defined integer result (a zero divisor, the most negative value over -1) out of the pseudo-random loop and covers them in dedicated scenarios whose expected values come from R5 and R9.

// File: rtl/div_pkg.sv
package div_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2
    } div_state_t;

    typedef struct packed {
        logic neg_quo;
        logic neg_rem;
        logic zero_div;
    } sign_ctl_t;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
    import div_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    input  logic         is_signed,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output sign_ctl_t    ctl
);

    logic a_neg;
    logic b_neg;

    always_comb begin
        a_neg        = is_signed & dividend[W-1];
        b_neg        = is_signed & divisor[W-1];
        mag_a        = a_neg ? (~dividend + 1'b1) : dividend;
        mag_b        = b_neg ? (~divisor + 1'b1) : divisor;
        ctl.neg_quo  = a_neg ^ b_neg;
        ctl.neg_rem  = a_neg;
        ctl.zero_div = (divisor == '0);
    end

endmodule

// File: rtl/div_iter_core.sv
module div_iter_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] mag_a,
    input  logic [W-1:0] mag_b,
    output logic         last,
    output logic [W-1:0] quo_mag,
    output logic [W-1:0] rem_mag
);

    localparam int ACC_W = 2 * W + 1;
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(W - 1);

    // acc = { partial remainder (W+1 bits) , quotient / pending dividend (W bits) }
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_next;
    logic [W-1:0]     dvsr;
    logic [CNT_W-1:0] cnt;

    logic [W:0]   part;
    logic [W-1:0] lo;
    logic         fits;
    logic [W-1:0] part_low;

    always_comb begin
        part     = acc[ACC_W-1:W];
        lo       = acc[W-1:0];
        fits     = (part >= {1'b0, dvsr});
        part_low = fits ? (part[W-1:0] - dvsr) : part[W-1:0];
        acc_next = {part_low, lo, fits};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            dvsr <= '0;
            cnt  <= '0;
        end else if (load) begin
            acc  <= {{W{1'b0}}, mag_a, 1'b0};
            dvsr <= mag_b;
            cnt  <= '0;
        end else if (step) begin
            acc  <= acc_next;
            cnt  <= cnt + 1'b1;
        end
    end

    assign last    = step && (cnt == LAST_CNT);
    assign quo_mag = acc[W-1:0];
    assign rem_mag = acc[ACC_W-1:W+1];

endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix
    import div_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    input  logic [W-1:0] raw_dividend,
    input  sign_ctl_t    ctl,
    output logic [W-1:0] quo_out,
    output logic [W-1:0] rem_out
);

    always_comb begin
        if (ctl.zero_div) begin
            quo_out = '1;
            rem_out = raw_dividend;
        end else begin
            quo_out = ctl.neg_quo ? (~quo_mag + 1'b1) : quo_mag;
            rem_out = ctl.neg_rem ? (~rem_mag + 1'b1) : rem_mag;
        end
    end

endmodule

// File: rtl/seq_divider.sv
module seq_divider
    import div_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_by_zero
);

    div_state_t state;
    sign_ctl_t  prep_ctl;
    sign_ctl_t  held_ctl;
    logic [W-1:0] held_dividend;
    logic [W-1:0] mag_a, mag_b;
    logic [W-1:0] quo_mag, rem_mag;
    logic [W-1:0] fix_q, fix_r;
    logic         accept;
    logic         core_last;

    assign busy   = (state != ST_IDLE);
    assign accept = start && (state == ST_IDLE);

    div_operand_prep #(.W(W)) u_prep (
        .dividend (dividend),
        .divisor  (divisor),
        .is_signed(is_signed),
        .mag_a    (mag_a),
        .mag_b    (mag_b),
        .ctl      (prep_ctl)
    );

    div_iter_core #(.W(W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .step   (state == ST_ITER),
        .mag_a  (mag_a),
        .mag_b  (mag_b),
        .last   (core_last),
        .quo_mag(quo_mag),
        .rem_mag(rem_mag)
    );

    div_sign_fix #(.W(W)) u_fix (
        .quo_mag     (quo_mag),
        .rem_mag     (rem_mag),
        .raw_dividend(held_dividend),
        .ctl         (held_ctl),
        .quo_out     (fix_q),
        .rem_out     (fix_r)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            done          <= 1'b0;
            quotient      <= '0;
            remainder     <= '0;
            div_by_zero   <= 1'b0;
            held_ctl      <= '0;
            held_dividend <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state         <= ST_ITER;
                        held_ctl      <= prep_ctl;
                        held_dividend <= dividend;
                    end
                end
                ST_ITER: begin
                    if (core_last) state <= ST_FIX;
                end
                ST_FIX: begin
                    quotient    <= fix_q;
                    remainder   <= fix_r;
                    div_by_zero <= held_ctl.zero_div;
                    done        <= 1'b1;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/div_checker.sv
module div_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic         div_by_zero
);

    localparam int LC_W = $clog2(W + 3) + 1;
    localparam logic [LC_W-1:0] LAT = LC_W'(W + 1);

    logic [LC_W-1:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (rst) lat_cnt <= '0;
        else if (start && !busy) lat_cnt <= '0;
        else if (lat_cnt != '1) lat_cnt <= lat_cnt + 1'b1;
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!busy && !done && !div_by_zero && quotient == '0 && remainder == '0));

    p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_latency_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_cnt == LAT));

    p_zero_div_quo_r5: assert property (@(posedge clk) disable iff (rst)
        div_by_zero |-> (quotient == '1));

    p_busy_from_start_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    p_hold_busy_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

endmodule

bind seq_divider div_checker #(.W(W)) u_div_checker (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .quotient   (quotient),
    .remainder  (remainder),
    .div_by_zero(div_by_zero)
);

// File: tb/tb_seq_divider.sv
`timescale 1ns/1ps
module tb_seq_divider;

    localparam int W   = 32;
    localparam int LAT = W + 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         is_signed = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_by_zero;
    logic [W-1:0] quotient, remainder;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    seq_divider #(.W(W)) dut (
        .clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder), .div_by_zero(div_by_zero)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Launch one division and wait for done; returns latency in edges after the start edge.
    task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b, input logic sgn,
                          input bit poke_busy, output int lat, output bit busy_ok);
        lat = 0;
        busy_ok = 1'b1;
        @(negedge clk);
        dividend = a; divisor = b; is_signed = sgn; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        // R7: disturb operands after acceptance
        dividend = ~a; divisor = b ^ 32'h5a5a_0001; is_signed = ~sgn;
        while (!done && lat < 100) begin
            if (!busy) busy_ok = 1'b0;
            if (poke_busy && lat == 5) begin
                dividend = 32'd1234; divisor = 32'd0; start = 1'b1;   // R6
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        if (busy) busy_ok = 1'b0;
    endtask

    task automatic run_case(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic sgn, input logic [W-1:0] eq, input logic [W-1:0] er,
                            input logic edz);
        int lat;
        bit bok;
        launch(a, b, sgn, 1'b0, lat, bok);
        check(req, "quotient", quotient, eq);
        check(req, "remainder", remainder, er);
        check(req, "div_by_zero", {31'd0, div_by_zero}, {31'd0, edz});
        check("R3", "latency", lat, LAT);
        check("R3", "busy/done framing", {31'd0, bok}, 32'd1);
    endtask

    task automatic test_reset();
        check("R1", "busy", {31'd0, busy}, 0);
        check("R1", "done", {31'd0, done}, 0);
        check("R1", "div_by_zero", {31'd0, div_by_zero}, 0);
        check("R1", "quotient", quotient, 0);
        check("R1", "remainder", remainder, 0);
    endtask

    task automatic test_unsigned_basic();
        run_case("R2", 32'd7, 32'd2, 1'b0, 32'd3, 32'd1, 1'b0);
        run_case("R2", 32'd100, 32'd7, 1'b0, 32'd14, 32'd2, 1'b0);
        run_case("R2", 32'd5, 32'd9, 1'b0, 32'd0, 32'd5, 1'b0);
        run_case("R2", 32'hffff_ffff, 32'd1, 1'b0, 32'hffff_ffff, 32'd0, 1'b0);
        run_case("R2", 32'hffff_ffff, 32'hffff_ffff, 1'b0, 32'd1, 32'd0, 1'b0);
        run_case("R2", 32'hffff_fffe, 32'hffff_ffff, 1'b0, 32'd0, 32'hffff_fffe, 1'b0);
        run_case("R2", 32'h8000_0000, 32'h0001_0000, 1'b0, 32'h0000_8000, 32'd0, 1'b0);
    endtask

    task automatic test_signed_basic();
        run_case("R4", -32'sd7, 32'sd4, 1'b1, -32'sd1, -32'sd3, 1'b0);
        run_case("R4", 32'sd7, -32'sd4, 1'b1, -32'sd1, 32'sd3, 1'b0);
        run_case("R4", -32'sd7, -32'sd4, 1'b1, 32'sd1, -32'sd3, 1'b0);
        run_case("R4", 32'sd7, 32'sd4, 1'b1, 32'sd1, 32'sd3, 1'b0);
        run_case("R4", 32'hffff_ffff, 32'd2, 1'b1, 32'd0, 32'hffff_ffff, 1'b0);
    endtask

    task automatic test_zero_divisor();
        run_case("R5", 32'd77, 32'd0, 1'b0, 32'hffff_ffff, 32'd77, 1'b1);
        run_case("R5", -32'sd5, 32'd0, 1'b1, 32'hffff_ffff, -32'sd5, 1'b1);
        run_case("R5", 32'd9, 32'd3, 1'b0, 32'd3, 32'd0, 1'b0);
    endtask

    task automatic test_most_negative();
        run_case("R9", 32'h8000_0000, 32'hffff_ffff, 1'b1, 32'h8000_0000, 32'd0, 1'b0);
        run_case("R9", 32'h8000_0000, 32'd2, 1'b1, 32'hc000_0000, 32'd0, 1'b0);
    endtask

    task automatic test_start_while_busy();
        int lat;
        bit bok;
        launch(32'd1000, 32'd30, 1'b0, 1'b1, lat, bok);
        check("R6", "quotient", quotient, 32'd33);
        check("R6", "remainder", remainder, 32'd10);
        check("R6", "div_by_zero", {31'd0, div_by_zero}, 0);
        check("R6", "latency", lat, LAT);
        check("R7", "framing", {31'd0, bok}, 32'd1);
    endtask

    task automatic test_hold();
        logic [W-1:0] q0, r0;
        q0 = quotient; r0 = remainder;
        dividend = 32'd3; divisor = 32'd0;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
        check("R8", "quotient held", quotient, q0);
        check("R8", "remainder held", remainder, r0);
        check("R8", "done low", {31'd0, done}, 0);
        check("R8", "busy low", {31'd0, busy}, 0);
    endtask

    task automatic test_patterns();
        logic [W-1:0] s1, s2, a, b;
        logic [W-1:0] eq, er;
        s1 = 32'h1234_5678;
        s2 = 32'h9e37_79b9;
        for (int i = 0; i < 24; i++) begin
            s1 = s1 ^ (s1 << 13); s1 = s1 ^ (s1 >> 17); s1 = s1 ^ (s1 << 5);
            s2 = s2 ^ (s2 << 13); s2 = s2 ^ (s2 >> 17); s2 = s2 ^ (s2 << 5);
            a = s1;
            b = s2 >> (i % 31);
            if (b == 0) b = 32'd3;
            if (i % 2 == 0) begin
                eq = a / b; er = a % b;
                run_case("R2", a, b, 1'b0, eq, er, 1'b0);
            end else begin
                if (a == 32'h8000_0000 && b == 32'hffff_ffff) b = 32'd7;
                eq = $signed(a) / $signed(b);
                er = $signed(a) % $signed(b);
                run_case("R4", a, b, 1'b1, eq, er, 1'b0);
            end
        end
    endtask

    bit finished = 1'b0;

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        test_reset();
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        test_reset();
        test_unsigned_basic();
        test_hold();
        test_signed_basic();
        test_zero_divisor();
        test_most_negative();
        test_start_while_busy();
        test_patterns();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule